// File: doc/BRIEF.md
# Dual-Channel Serial DAC Front End

This block is the digital side of a two-channel voltage-output converter. A host shifts a word in on a serial data pin, one bit per rising edge of a serial clock. The serial clock only counts while an active-low select is held low. Each word starts with a two-bit channel address, followed by the code, most significant bit first. When the select is released, a word of the exact expected length is written into the input register of the channel or channels it addresses. Any other length is dropped.

Each channel keeps its code in two stages: an input register and a DAC register. The DAC register drives the converter and changes only when that channel's load strobe is high, or when the reset-to-scale input is asserted. The reset-to-scale input forces both DAC registers to zero or to mid-scale, chosen by a scale-select pin. A shutdown input is passed on to a power-down output, and all stored codes are kept while it is active.

All inputs are taken to be synchronous to the system clock `clk`, which must run at least four times faster than the serial clock. The code width `CODE_W` is a parameter (12 or 10 in practice). The port list is the same for every width.

Top module: `dual_dac_front`

## Requirements
- R1: After `rst_n` is sampled low, `code_a`, `code_b` and `pwr_down` are all zero.
- R2: A word is `CODE_W+2` bits long and is sampled on each rising edge of `sclk` while `cs_n` is low. The first two bits are the address, then the code follows MSB first. The word is taken on the clock edge that first samples `cs_n` high again.
- R3: Address encoding: 2'b01 writes channel A, 2'b10 writes channel B, 2'b11 writes both, and 2'b00 writes neither. A channel that is not addressed keeps its input register.
- R4: If the number of `sclk` rising edges seen while `cs_n` is low is not exactly `CODE_W+2`, the word is discarded and no input register changes.
- R5: Rising edges of `sclk` while `cs_n` is high have no effect: they neither count toward nor corrupt the next word.
- R6: A DAC output changes only through its load strobe or `rs`. While `ld_a` (or `ld_b`) is high, the next clock edge copies that channel's input register to `code_a` (or `code_b`). Both strobes together update both channels on the same edge.
- R7: While `rs` is high, the next clock edge sets both outputs to zero if `half_sel` is low, or to a code with only the MSB set if `half_sel` is high. `rs` overrides the load strobes.
- R8: `pwr_down` equals `shdn` delayed by one clock. Input registers and DAC codes are kept across shutdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial bit clock, sampled by `clk` |
| sdi | input | 1 | Serial data |
| cs_n | input | 1 | Active-low select; a rising edge ends a word |
| ld_a | input | 1 | Load strobe for channel A |
| ld_b | input | 1 | Load strobe for channel B |
| rs | input | 1 | Reset both DAC codes to scale |
| half_sel | input | 1 | Reset target: 0 gives zero, 1 gives mid-scale |
| shdn | input | 1 | Shutdown request |
| code_a | output | CODE_W | Channel A DAC code |
| code_b | output | CODE_W | Channel B DAC code |
| pwr_down | output | 1 | Power-down flag for the analog side |

## Verification
Every result is due exactly one `clk` edge after the stimulus that causes it is sampled. A written word reaches the input register on the edge that sees `cs_n` high. A strobe or `rs` reaches the outputs on the next edge, and so does `shdn` reaching `pwr_down`. The bench drives every input on a falling edge of `clk` and samples on the following falling edge, so each check sits half a cycle after the one rising edge that must produce it. Input registers have no output of their own, so words are checked by loading them and reading `code_a` and `code_b`.

// File: rtl/dual_dac_pkg.sv
// Shared types for the dual-channel DAC front end.
package dual_dac_pkg;
    // Channel address carried in the first two bits of each serial word.
    typedef enum logic [1:0] {
        SEL_NONE = 2'b00,
        SEL_A    = 2'b01,
        SEL_B    = 2'b10,
        SEL_AB   = 2'b11
    } chan_sel_e;
endpackage

// File: rtl/dac_serial_rx.sv
// Serial word receiver.
// What it does: shifts sdi on each sclk rising edge seen while cs_n is low,
// counts the edges, and on the cs_n rising edge presents the address and code
// with a one-cycle valid, only if exactly FRAME_W edges were counted.
// Assumes: sclk, sdi and cs_n are synchronous to clk, and each sclk level
// lasts at least two clk cycles.
module dac_serial_rx #(
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              sdi_i,
    input  logic              cs_n_i,
    output logic              vld_o,
    output logic [1:0]        addr_o,
    output logic [CODE_W-1:0] data_o
);
    localparam int FRAME_W = CODE_W + 2;
    localparam int CNT_W   = $clog2(FRAME_W + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_W + 1);

    logic               sclk_q;
    logic               cs_q;
    logic [FRAME_W-1:0] shreg;
    logic [CNT_W-1:0]   cnt;
    logic               bit_tick;

    // Rising sclk edge while the select is active.
    assign bit_tick = sclk_i && !sclk_q && !cs_n_i;

    // Edge-detect history for sclk and cs_n.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            cs_q   <= 1'b1;
        end else begin
            sclk_q <= sclk_i;
            cs_q   <= cs_n_i;
        end
    end

    // Shift register and saturating edge counter; the count clears while deselected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            cnt   <= '0;
        end else if (cs_n_i) begin
            cnt <= '0;
        end else if (bit_tick) begin
            shreg <= {shreg[FRAME_W-2:0], sdi_i};
            if (cnt != CNT_OVER) cnt <= cnt + 1'b1;
        end
    end

    // Word release on the select's rising edge.
    assign vld_o  = cs_n_i && !cs_q && (cnt == CNT_FULL);
    assign addr_o = shreg[FRAME_W-1 -: 2];
    assign data_o = shreg[CODE_W-1:0];

    // Deselected sclk activity must leave the shift register alone.
    p_deselect_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n_i && cs_q) |=> $stable(shreg))
        else $error("serial shift while deselected");
endmodule

// File: rtl/dac_channel.sv
// One DAC channel: input register followed by DAC register.
// What it does: the input register takes a received code when written; the DAC
// register copies it while the load strobe is high, and is forced to zero or
// mid-scale while the reset-to-scale input is high (which wins over the load).
// Assumes: all controls are synchronous to clk.
module dac_channel #(
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [CODE_W-1:0] wdata_i,
    input  logic              ld_i,
    input  logic              rs_i,
    input  logic              half_i,
    output logic [CODE_W-1:0] dac_o
);
    localparam logic [CODE_W-1:0] HALF_CODE = {1'b1, {(CODE_W-1){1'b0}}};

    logic [CODE_W-1:0] in_q;
    logic [CODE_W-1:0] dac_q;

    // Input register: captures an addressed, well-formed word.
    always_ff @(posedge clk) begin
        if (!rst_n)    in_q <= '0;
        else if (wr_i) in_q <= wdata_i;
    end

    // DAC register: reset-to-scale first, then load.
    always_ff @(posedge clk) begin
        if (!rst_n)    dac_q <= '0;
        else if (rs_i) dac_q <= half_i ? HALF_CODE : '0;
        else if (ld_i) dac_q <= in_q;
    end

    assign dac_o = dac_q;

    p_rs_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rs_i |=> (dac_q == ($past(half_i) ? HALF_CODE : '0)))
        else $error("reset-to-scale value wrong");

    p_load_copies_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!rs_i && ld_i) |=> (dac_q == $past(in_q)))
        else $error("load did not copy input register");

    p_dac_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!rs_i && !ld_i) |=> $stable(dac_q))
        else $error("DAC code moved without load");

    p_input_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(in_q))
        else $error("input register moved without write");
endmodule

// File: rtl/dual_dac_front.sv
// Dual-channel serial DAC front end (top).
// What it does: one serial receiver feeds two channels picked by the word's
// address bits; per-channel load strobes, shared reset-to-scale, and a
// registered power-down flag.
// Assumes: all inputs are synchronous to clk; clk is at least four times sclk.
module dual_dac_front
    import dual_dac_pkg::*;
#(
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              sdi,
    input  logic              cs_n,
    input  logic              ld_a,
    input  logic              ld_b,
    input  logic              rs,
    input  logic              half_sel,
    input  logic              shdn,
    output logic [CODE_W-1:0] code_a,
    output logic [CODE_W-1:0] code_b,
    output logic              pwr_down
);
    localparam int N_CH = 2;

    logic              word_vld;
    logic [1:0]        word_addr;
    logic [CODE_W-1:0] word_data;
    chan_sel_e         sel;
    logic [N_CH-1:0]   wr_vec;
    logic [N_CH-1:0]   ld_vec;
    logic [CODE_W-1:0] dac_vec [N_CH];
    logic              pd_q;

    dac_serial_rx #(.CODE_W(CODE_W)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .sclk_i (sclk),
        .sdi_i  (sdi),
        .cs_n_i (cs_n),
        .vld_o  (word_vld),
        .addr_o (word_addr),
        .data_o (word_data)
    );

    // Channel decode: bit 0 addresses A, bit 1 addresses B.
    always_comb begin
        sel       = chan_sel_e'(word_addr);
        wr_vec[0] = word_vld && (sel == SEL_A || sel == SEL_AB);
        wr_vec[1] = word_vld && (sel == SEL_B || sel == SEL_AB);
    end

    assign ld_vec = {ld_b, ld_a};

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        dac_channel #(.CODE_W(CODE_W)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_i    (wr_vec[ch]),
            .wdata_i (word_data),
            .ld_i    (ld_vec[ch]),
            .rs_i    (rs),
            .half_i  (half_sel),
            .dac_o   (dac_vec[ch])
        );
    end

    // Power-down flag: one-cycle registered copy of the shutdown request.
    always_ff @(posedge clk) begin
        if (!rst_n) pd_q <= 1'b0;
        else        pd_q <= shdn;
    end

    assign code_a   = dac_vec[0];
    assign code_b   = dac_vec[1];
    assign pwr_down = pd_q;

    p_pd_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (pd_q == $past(shdn)))
        else $error("power-down flag lags wrongly");
endmodule

// File: tb/sim_dual_dac_front.sv
module sim_dual_dac_front;
    localparam int W = 12;
    localparam int FRAME = W + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, sdi = 1'b0, cs_n = 1'b1;
    logic ld_a = 1'b0, ld_b = 1'b0, rs = 1'b0, half_sel = 1'b0, shdn = 1'b0;
    logic [W-1:0] code_a, code_b;
    logic pwr_down;

    int n_chk = 0, n_err = 0;
    bit finished = 0;

    logic [W-1:0] m_in_a = '0, m_in_b = '0, m_dac_a = '0, m_dac_b = '0;

    always #10 clk = ~clk;

    dual_dac_front #(.CODE_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdi(sdi), .cs_n(cs_n),
        .ld_a(ld_a), .ld_b(ld_b), .rs(rs), .half_sel(half_sel), .shdn(shdn),
        .code_a(code_a), .code_b(code_b), .pwr_down(pwr_down)
    );

    function automatic logic [W-1:0] scale_code(input logic half);
        return half ? {1'b1, {(W-1){1'b0}}} : '0;
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_codes(input string req);
        check(req, code_a, m_dac_a);
        check(req, code_b, m_dac_b);
    endtask

    // Sends nbits bits of {addr,data} MSB first (zeros past the word), then deselects.
    task automatic send_frame(input logic [1:0] addr, input logic [W-1:0] data, input int nbits);
        logic [FRAME-1:0] word = {addr, data};
        @(negedge clk) cs_n = 1'b0;
        for (int i = 0; i < nbits; i++) begin
            sdi = (i < FRAME) ? word[FRAME-1-i] : 1'b0;
            repeat (2) @(negedge clk);
            sclk = 1'b1;
            repeat (2) @(negedge clk);
            sclk = 1'b0;
        end
        @(negedge clk) cs_n = 1'b1;
        @(negedge clk);
        if (nbits == FRAME) begin
            if (addr[0]) m_in_a = data;
            if (addr[1]) m_in_b = data;
        end
        check("R6 codes unchanged by write", code_a, m_dac_a);
        check("R6 codes unchanged by write", code_b, m_dac_b);
    endtask

    task automatic do_load(input logic a, input logic b, input string req);
        @(negedge clk) begin ld_a = a; ld_b = b; end
        @(negedge clk) begin ld_a = 1'b0; ld_b = 1'b0; end
        if (a) m_dac_a = m_in_a;
        if (b) m_dac_b = m_in_b;
        check_codes(req);
    endtask

    task automatic do_rs(input logic half, input logic a, input logic b);
        @(negedge clk) begin rs = 1'b1; half_sel = half; ld_a = a; ld_b = b; end
        @(negedge clk);
        m_dac_a = scale_code(half);
        m_dac_b = scale_code(half);
        check_codes("R7 reset-to-scale");
        @(negedge clk);
        check_codes("R7 rs held overrides strobes");
        rs = 1'b0; ld_a = 1'b0; ld_b = 1'b0;
    endtask

    task automatic stray_clocks(input int n);
        @(negedge clk) cs_n = 1'b1;
        for (int i = 0; i < n; i++) begin
            sdi = i[0];
            repeat (2) @(negedge clk) sclk = 1'b1;
            repeat (2) @(negedge clk) sclk = 1'b0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        check("R1 reset code_a", code_a, '0);
        check("R1 reset code_b", code_b, '0);
        check("R1 reset pwr_down", W'(pwr_down), '0);
        rst_n = 1'b1;

        // R2/R3: per-address words, loaded together and separately.
        send_frame(2'b01, 12'hA5C, FRAME);
        send_frame(2'b10, 12'h3B1, FRAME);
        do_load(1'b1, 1'b1, "R6 both strobes together");
        send_frame(2'b11, 12'h7E2, FRAME);
        do_load(1'b1, 1'b0, "R3 both-address word, load A");
        do_load(1'b0, 1'b1, "R3 both-address word, load B");
        send_frame(2'b00, 12'hFFF, FRAME);
        do_load(1'b1, 1'b1, "R3 null address writes nothing");

        // R4: short and long words dropped.
        send_frame(2'b11, 12'h123, FRAME - 1);
        do_load(1'b1, 1'b1, "R4 short word discarded");
        send_frame(2'b11, 12'h456, FRAME + 1);
        do_load(1'b1, 1'b1, "R4 long word discarded");

        // R5: stray clocks while deselected, then a clean word.
        stray_clocks(5);
        send_frame(2'b01, 12'h9C3, FRAME);
        do_load(1'b1, 1'b0, "R5 stray clocks ignored");

        // R7: both targets, with strobes held.
        do_rs(1'b1, 1'b1, 1'b1);
        do_rs(1'b0, 1'b1, 1'b0);

        // R8: shutdown keeps state.
        @(negedge clk) shdn = 1'b1;
        @(negedge clk);
        check("R8 pwr_down set", W'(pwr_down), W'(1));
        check_codes("R8 codes kept in shutdown");
        send_frame(2'b10, 12'h0F0, FRAME);
        do_load(1'b0, 1'b1, "R8 loads work in shutdown");
        @(negedge clk) shdn = 1'b0;
        @(negedge clk);
        check("R8 pwr_down clear", W'(pwr_down), '0);
        do_load(1'b1, 1'b1, "R8 registers kept after shutdown");

        // Constrained random mix.
        for (int it = 0; it < 250; it++) begin
            int op = int'($urandom_range(0, 9));
            if (op < 5) begin
                int len = FRAME;
                if ($urandom_range(0, 7) == 0) len = FRAME + ($urandom_range(0, 1) ? 1 : -2);
                send_frame(2'($urandom), W'($urandom), len);
            end else if (op < 8) begin
                do_load(1'($urandom), 1'($urandom), "R6 random load");
            end else if (op == 8) begin
                do_rs(1'($urandom), 1'($urandom), 1'($urandom));
            end else begin
                stray_clocks(int'($urandom_range(1, 3)));
            end
        end
        do_load(1'b1, 1'b1, "R2 final random state");

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule